// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Controller

This block turns doorbell writes into interrupt requests for up to 256 vectors. A write to the doorbell offset carries a vector number in its data word. The block then latches a pending flag for that vector. Each vector also has an enable flag. One registered interrupt line goes high while any vector is both pending and enabled, so the host sees a single request line.

Doorbell writes can arrive on two paths. The inbound port carries message writes from the link side and is decoded only for the doorbell offset. The register port is the host's 32-bit slave interface. On it the host reads and clears the pending words, reads and writes the enable words, and may also ring the doorbell.

Pending flags are cleared by writing ones. Because events are edge-like, each doorbell write is one event, and the host must clear the flag before the next event on that vector can be told apart. Addresses are byte offsets, and the two low address bits are ignored.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After synchronous reset every pending bit and every enable bit reads zero, and `irq` is low.
- R2: A doorbell write to offset 0x7C with data n < 256 sets the pending flag of vector n. The flag is visible from the next cycle as bit n mod 32 of the status word at offset 0x80 + 4*(n/32). The write may come from either port.
- R3: A doorbell write whose data is 256 or more changes no pending bit.
- R4: A register-port write to a status word clears each pending bit whose data bit is 1 and leaves each pending bit whose data bit is 0.
- R5: The enable words at offsets 0xA0 to 0xBC can be read and written. They use the same vector-to-bit mapping as the status words, and any value, including all zeros, is held until rewritten.
- R6: `irq` is the OR over all vectors of (pending AND enable), registered once, so it changes one cycle after the state that causes it.
- R7: When a doorbell for vector n and a status clear of bit n land in the same cycle, the pending flag of n stays set. Other bits in the same clear are still cleared.
- R8: A disabled vector still records doorbell events. Setting its enable bit later raises `irq`.
- R9: A register-port read returns its data one cycle after `reg_rd`. Reads of the doorbell offset and of any offset outside the status and enable words return zero.
- R10: An inbound-port write to any offset other than the doorbell changes neither pending nor enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ib_wr | input | 1 | Inbound message write strobe |
| ib_addr | input | 8 | Inbound write byte offset |
| ib_wdata | input | 32 | Inbound write data (vector number at the doorbell) |
| reg_wr | input | 1 | Register-port write strobe |
| reg_rd | input | 1 | Register-port read strobe |
| reg_addr | input | 8 | Register-port byte offset |
| reg_wdata | input | 32 | Register-port write data |
| reg_rdata | output | 32 | Register-port read data, valid one cycle after `reg_rd` |
| irq | output | 1 | Aggregated interrupt request |

## Verification
The bench builds the block with its default parameters: 256 vectors, 32-bit words and an 8-bit offset. This brings the extreme vectors 0 and 255 within reach, along with the first out-of-range value 256 and the last status and enable words at 0x9C and 0xBC. Using two write ports allows a doorbell and a clear of the same bit to be driven in one cycle. Interrupt timing is probed in the cycle right after an enable change and again one cycle later, to expose the single register stage.

// File: rtl/msi_dbell_pkg.sv
package msi_dbell_pkg;

    typedef enum logic [1:0] {
        REG_NONE     = 2'd0,
        REG_DOORBELL = 2'd1,
        REG_STATUS   = 2'd2,
        REG_ENABLE   = 2'd3
    } reg_region_e;

    typedef struct packed {
        reg_region_e region;
        logic [7:0]  word;
    } reg_sel_t;

    function automatic logic in_window(
        input logic [31:0] a,
        input logic [31:0] base,
        input int          nwords
    );
        return (a >= base) && (a < base + 32'(4 * nwords));
    endfunction

    function automatic logic [7:0] word_index(
        input logic [31:0] a,
        input logic [31:0] base
    );
        logic [31:0] diff;
        diff = (a - base) >> 2;
        return diff[7:0];
    endfunction

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_dbell_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 8,
    parameter int DB_OFS    = 'h7C,
    parameter int ST_BASE   = 'h80,
    parameter int EN_BASE   = 'hA0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [31:0] DB32 = 32'(DB_OFS);
    localparam logic [31:0] ST32 = 32'(ST_BASE);
    localparam logic [31:0] EN32 = 32'(EN_BASE);

    logic [31:0] a32;

    always_comb begin
        a32        = 32'(addr);
        sel.region = REG_NONE;
        sel.word   = '0;
        if (a32[31:2] == DB32[31:2]) begin
            sel.region = REG_DOORBELL;
        end else if (in_window(a32, ST32, NUM_WORDS)) begin
            sel.region = REG_STATUS;
            sel.word   = word_index(a32, ST32);
        end else if (in_window(a32, EN32, NUM_WORDS)) begin
            sel.region = REG_ENABLE;
            sel.word   = word_index(a32, EN32);
        end
    end

endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
    parameter int NUM_VEC = 256,
    parameter int DATA_W  = 32
) (
    input  logic                                valid,
    input  logic [DATA_W-1:0]                   vec,
    output logic [NUM_VEC/DATA_W-1:0][DATA_W-1:0] onehot
);
    localparam int NUM_WORDS = NUM_VEC / DATA_W;
    localparam int BIT_W     = $clog2(DATA_W);

    logic in_range;
    assign in_range = valid && (vec < DATA_W'(NUM_VEC));

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_comb begin
            onehot[w] = '0;
            if (in_range && ((vec >> BIT_W) == DATA_W'(w)))
                onehot[w] = DATA_W'(1) << vec[BIT_W-1:0];
        end
    end

endmodule

// File: rtl/msi_vector_bank.sv
module msi_vector_bank #(
    parameter int NUM_VEC = 256,
    parameter int DATA_W  = 32
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_VEC/DATA_W-1:0][DATA_W-1:0] set_mask,
    input  logic [NUM_VEC/DATA_W-1:0][DATA_W-1:0] clr_mask,
    input  logic                                  en_we,
    input  logic [7:0]                            en_word,
    input  logic [DATA_W-1:0]                     en_wdata,
    output logic [NUM_VEC/DATA_W-1:0][DATA_W-1:0] pending_q,
    output logic [NUM_VEC/DATA_W-1:0][DATA_W-1:0] enable_q
);
    localparam int NUM_WORDS = NUM_VEC / DATA_W;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                pending_q[w] <= '0;
                enable_q[w]  <= '0;
            end else begin
                // a set wins over a clear of the same bit
                pending_q[w] <= (pending_q[w] & ~clr_mask[w]) | set_mask[w];
                if (en_we && (en_word == 8'(w)))
                    enable_q[w] <= en_wdata;
            end
        end
    end

    AST_DB_SETS: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((pending_q & $past(set_mask)) == $past(set_mask))); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ((set_mask & clr_mask) != '0) |=> ((pending_q & $past(set_mask & clr_mask)) != '0)); // R7
    AST_W1C: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~set_mask) != '0) |=> ((pending_q & $past(clr_mask & ~set_mask)) == '0)); // R4
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> (enable_q == $past(enable_q))); // R5

endmodule

// File: rtl/msi_irq_merge.sv
module msi_irq_merge #(
    parameter int NUM_VEC = 256,
    parameter int DATA_W  = 32
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_VEC/DATA_W-1:0][DATA_W-1:0] pending,
    input  logic [NUM_VEC/DATA_W-1:0][DATA_W-1:0] enable,
    output logic                                  irq_q
);
    logic any_live;
    assign any_live = |(pending & enable);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= any_live;
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        any_live |=> irq_q); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !any_live |=> !irq_q); // R6

endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
    import msi_dbell_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int DB_OFS  = 'h7C,
    parameter int ST_BASE = 'h80,
    parameter int EN_BASE = 'hA0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ib_wr,
    input  logic [ADDR_W-1:0] ib_addr,
    input  logic [DATA_W-1:0] ib_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int NUM_WORDS = NUM_VEC / DATA_W;
    localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    typedef logic [NUM_WORDS-1:0][DATA_W-1:0] bank_t;

    reg_sel_t ib_sel, reg_sel;
    bank_t    ib_set, reg_set, set_mask, clr_mask, pending, enable;
    logic     ib_db, reg_db, en_we;

    msi_addr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .DB_OFS(DB_OFS),
                      .ST_BASE(ST_BASE), .EN_BASE(EN_BASE))
        u_ib_dec (.addr(ib_addr), .sel(ib_sel));

    msi_addr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .DB_OFS(DB_OFS),
                      .ST_BASE(ST_BASE), .EN_BASE(EN_BASE))
        u_reg_dec (.addr(reg_addr), .sel(reg_sel));

    // the inbound path only ever rings the doorbell
    assign ib_db  = ib_wr  && (ib_sel.region  == REG_DOORBELL);
    assign reg_db = reg_wr && (reg_sel.region == REG_DOORBELL);

    msi_vec_decode #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W))
        u_ib_vec (.valid(ib_db), .vec(ib_wdata), .onehot(ib_set));

    msi_vec_decode #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W))
        u_reg_vec (.valid(reg_db), .vec(reg_wdata), .onehot(reg_set));

    assign set_mask = ib_set | reg_set;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
        assign clr_mask[w] = (reg_wr && (reg_sel.region == REG_STATUS) &&
                              (reg_sel.word == 8'(w))) ? reg_wdata : '0;
    end

    assign en_we = reg_wr && (reg_sel.region == REG_ENABLE);

    msi_vector_bank #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W))
        u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_mask (set_mask),
            .clr_mask (clr_mask),
            .en_we    (en_we),
            .en_word  (reg_sel.word),
            .en_wdata (reg_wdata),
            .pending_q(pending),
            .enable_q (enable)
        );

    msi_irq_merge #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W))
        u_merge (
            .clk    (clk),
            .rst    (rst),
            .pending(pending),
            .enable (enable),
            .irq_q  (irq)
        );

    logic [WORD_W-1:0] rd_word;
    assign rd_word = reg_sel.word[WORD_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_sel.region)
                REG_STATUS: reg_rdata <= pending[rd_word];
                REG_ENABLE: reg_rdata <= enable[rd_word];
                default:    reg_rdata <= '0;
            endcase
        end
    end

    AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ib_db && (ib_wdata >= DATA_W'(NUM_VEC)) && !reg_wr) |=> (pending == $past(pending))); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && ((reg_sel.region == REG_NONE) || (reg_sel.region == REG_DOORBELL)))
        |=> (reg_rdata == '0)); // R9
    AST_IB_NO_SIDE: assert property (@(posedge clk) disable iff (rst)
        (ib_wr && !ib_db && !reg_wr) |=> ((pending == $past(pending)) && (enable == $past(enable)))); // R10

endmodule

// File: tb/sim_msi_doorbell_ctrl.sv
module sim_msi_doorbell_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ib_wr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  ib_addr = '0, reg_addr = '0;
    logic [31:0] ib_wdata = '0, reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    msi_doorbell_ctrl u0 (
        .clk(clk), .rst(rst),
        .ib_wr(ib_wr), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic ib_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); ib_wr = 1'b1; ib_addr = a; ib_wdata = d;
        @(negedge clk); ib_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic clear_all();
        for (int w = 0; w < 8; w++) begin
            reg_write(8'h80 + 8'(4 * w), 32'hFFFF_FFFF);
            reg_write(8'hA0 + 8'(4 * w), 32'h0);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        for (int w = 0; w < 8; w++) begin
            reg_read(8'h80 + 8'(4 * w), d);
            chk("R1 status word", d, 32'h0);
            reg_read(8'hA0 + 8'(4 * w), d);
            chk("R1 enable word", d, 32'h0);
        end
    endtask

    task automatic t_doorbell();
        logic [31:0] d;
        ib_write(8'h7C, 32'd37);
        reg_read(8'h84, d);  chk("R2 vector 37", d, 32'h0000_0020);
        ib_write(8'h7C, 32'd0);
        reg_read(8'h80, d);  chk("R2 vector 0", d, 32'h0000_0001);
        ib_write(8'h7C, 32'd255);
        reg_read(8'h9C, d);  chk("R2 vector 255", d, 32'h8000_0000);
        reg_write(8'h7C, 32'd100);
        reg_read(8'h8C, d);  chk("R2 reg-port doorbell 100", d, 32'h0000_0010);
        reg_read(8'h7C, d);  chk("R9 doorbell reads zero", d, 32'h0);
    endtask

    task automatic t_range();
        logic [31:0] d;
        logic [31:0] exp_w [8];
        exp_w = '{32'h1, 32'h20, 32'h0, 32'h10, 32'h0, 32'h0, 32'h0, 32'h8000_0000};
        ib_write(8'h7C, 32'd256);
        ib_write(8'h7C, 32'hFFFF_FFFF);
        ib_write(8'h7C, 32'd288);
        for (int w = 0; w < 8; w++) begin
            reg_read(8'h80 + 8'(4 * w), d);
            chk("R3 out-of-range doorbell ignored", d, exp_w[w]);
        end
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        ib_write(8'h7C, 32'd33);
        reg_write(8'h84, 32'h0000_0020);
        reg_read(8'h84, d);  chk("R4 clear bit5 keeps bit1", d, 32'h0000_0002);
        reg_write(8'h84, 32'h0);
        reg_read(8'h84, d);  chk("R4 write zero keeps", d, 32'h0000_0002);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        reg_write(8'hA4, 32'hA5A5_5A5A);
        reg_write(8'hBC, 32'h8000_0001);
        reg_read(8'hA4, d);  chk("R5 enable word1", d, 32'hA5A5_5A5A);
        reg_read(8'hBC, d);  chk("R5 enable word7", d, 32'h8000_0001);
        reg_read(8'hA0, d);  chk("R5 enable word0 untouched", d, 32'h0);
        reg_write(8'hA4, 32'h0);
        reg_read(8'hA4, d);  chk("R5 enable back to zero", d, 32'h0);
    endtask

    task automatic t_irq();
        clear_all();
        @(negedge clk);
        chk("R6 irq low when idle", {31'b0, irq}, 32'h0);
        ib_write(8'h7C, 32'd200);
        @(negedge clk);
        chk("R8 disabled pending no irq", {31'b0, irq}, 32'h0);
        reg_write(8'hB8, 32'h0000_0100);
        chk("R6 irq one-cycle latency", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 enable raises irq", {31'b0, irq}, 32'h1);
        reg_write(8'hB8, 32'h0000_0200);
        @(negedge clk);
        chk("R5 other bit enabled only", {31'b0, irq}, 32'h0);
        reg_write(8'hB8, 32'h0000_0100);
        @(negedge clk);
        chk("R6 irq back", {31'b0, irq}, 32'h1);
        reg_write(8'h98, 32'h0000_0100);
        chk("R6 irq held one cycle", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R6 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        ib_write(8'h7C, 32'd64);
        @(negedge clk);
        ib_wr = 1'b1; ib_addr = 8'h7C; ib_wdata = 32'd70;
        reg_wr = 1'b1; reg_addr = 8'h88; reg_wdata = 32'h0000_0041;
        @(negedge clk);
        ib_wr = 1'b0; reg_wr = 1'b0;
        reg_read(8'h88, d);
        chk("R7 set wins same-cycle clear", d, 32'h0000_0040);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        reg_read(8'h00, d);  chk("R9 offset 0x00", d, 32'h0);
        reg_read(8'h40, d);  chk("R9 offset 0x40", d, 32'h0);
        reg_read(8'hC0, d);  chk("R9 offset 0xC0", d, 32'h0);
        reg_read(8'h78, d);  chk("R9 offset 0x78", d, 32'h0);
    endtask

    task automatic t_ib_offset();
        logic [31:0] d;
        reg_write(8'hA8, 32'h0000_00F0);
        ib_write(8'h88, 32'hFFFF_FFFF);
        ib_write(8'hA8, 32'h0);
        ib_write(8'h78, 32'd3);
        reg_read(8'h88, d);  chk("R10 inbound status write ignored", d, 32'h0000_0040);
        reg_read(8'hA8, d);  chk("R10 inbound enable write ignored", d, 32'h0000_00F0);
        reg_read(8'h80, d);  chk("R10 inbound non-doorbell no set", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_doorbell();
        t_range();
        t_w1c();
        t_enable();
        t_irq();
        t_collision();
        t_unmapped();
        t_ib_offset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule